// File: doc/BRIEF.md
# Multi-cycle restoring integer divider

This block divides an unsigned dividend by an unsigned divisor. It returns the floor quotient and the remainder. Each step retires one digit of radix 2^DIGIT_LOG2. The step is non-performing: it forms a trial difference between the shifted partial remainder and the divisor. When that difference would be negative, the step keeps the shifted partial remainder instead of adding the divisor back. A division takes STEPS = ceil(DVD_W / DIGIT_LOG2) steps. When DVD_W is not a multiple of the digit size, the dividend is padded with zeros at the top.

A caller puts the operands on the inputs and pulses `start`. `ready` falls on the next cycle and rises again when the result is on the outputs. When the divisor was zero, `div_zero` is raised and the quotient and remainder carry no defined value. The UNROLL parameter selects one of two datapaths. The iterative form reuses a single step circuit and accepts a new division only while idle. The unrolled form has one register stage per step and can accept a new division on every cycle.

Top module: `restoring_divider`

## Requirements
- R1: During and after a synchronous active-low reset, `ready` is 1, `quotient` and `remainder` are 0 and `div_zero` is 0.
- R2: For a nonzero divisor, the finished result satisfies dividend = quotient*divisor + remainder with remainder < divisor.
- R3: When the divisor exceeds the dividend, the quotient is 0 and the remainder equals the dividend.
- R4: After `start` is taken at a clock edge, `ready` is 0 from that edge until exactly STEPS = ceil(DVD_W/DIGIT_LOG2) edges later, when it returns to 1 with the result on the outputs.
- R5: In the iterative form, a `start` while `ready` is 0 is ignored, and the running division finishes with its original operands.
- R6: `div_zero` is 1 with a result whose divisor was 0, and 0 with a result whose divisor was nonzero.
- R7: In the unrolled form, starts on consecutive cycles each produce their own result STEPS edges after their start, in issue order, and `ready` stays 0 until the last one is out.
- R8: Between results, `quotient`, `remainder` and `div_zero` hold their values.
- R9: A reset during a division aborts it, so that `ready` is 1 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a division with the present operands |
| ready | output | 1 | Idle, with the result valid |
| dividend | input | DVD_W | Unsigned dividend |
| divisor | input | DVS_W | Unsigned divisor |
| quotient | output | DVD_W | Floor quotient |
| remainder | output | DVS_W | Remainder |
| div_zero | output | 1 | The last finished division had a zero divisor |

## Verification
The same operands go to six instances at once, covering digit sizes of 1, 2 and 3 bits in both forms. A digit-size error therefore shows up against the other instances, and the 3-bit digit exercises the zero padding of an 8-bit dividend. A fixed vector table holds the edge cases: divisor 1, a divisor larger than the dividend, all-ones operands and a zero dividend. These separate a wrong keep-or-commit decision from a wrong shift. Random operands follow. Directed sequences then issue a second start during a run, which tells the iterative form's refusal apart from the unrolled form's overlap. They also issue back-to-back starts, a zero divisor and a reset in the middle of a division.

// File: rtl/div_pkg.sv
// Package: shared sizing helpers for the restoring divider.
// Assumes digit sizes of one bit or more.
package div_pkg;

    // Number of digit steps needed to cover a dividend of the given width.
    function automatic int digit_steps(input int dvd_w, input int dig_w);
        return (dvd_w + dig_w - 1) / dig_w;
    endfunction

endpackage

// File: rtl/div_digit_step.sv
// Module: div_digit_step
// One radix-2^DIG_W non-performing restoring step, as pure combinational logic.
// The partial remainder shifts in one dividend bit at a time. A trial
// subtraction is committed only when it does not borrow, and each commit
// yields a 1 quotient bit. Assumes res_i < dvs_i on entry, which keeps
// res_o < dvs_i on exit. A zero divisor gives undefined results.
module div_digit_step #(
    parameter int DVS_W = 6,
    parameter int DIG_W = 1
) (
    input  logic [DVS_W-1:0] res_i,
    input  logic [DVS_W-1:0] dvs_i,
    input  logic [DIG_W-1:0] bits_i,
    output logic [DVS_W-1:0] res_o,
    output logic [DIG_W-1:0] q_o
);
    localparam int WIDE_W = DVS_W + 1;

    // Chain DIG_W shift/trial/select sub-steps, MSB of the digit first.
    always_comb begin
        logic [DVS_W-1:0]  acc;
        logic [WIDE_W-1:0] wide;
        logic [WIDE_W:0]   diff;
        acc  = res_i;
        q_o  = '0;
        wide = '0;
        diff = '0;
        for (int j = DIG_W - 1; j >= 0; j--) begin
            wide = {acc, bits_i[j]};
            diff = {1'b0, wide} - {2'b00, dvs_i};
            if (!diff[WIDE_W]) begin
                acc    = diff[DVS_W-1:0];
                q_o[j] = 1'b1;
            end else begin
                acc = wide[DVS_W-1:0];
            end
        end
        res_o = acc;
    end
endmodule

// File: rtl/div_iter_core.sv
// Module: div_iter_core
// Iterative datapath: one div_digit_step reused for STEPS cycles.
// The dividend shift register is filled with quotient digits as the dividend
// bits are consumed. Starts are taken only while idle. Synchronous active-low reset.
module div_iter_core #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 6,
    parameter int DIG_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             ready,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder,
    output logic             div_zero
);
    localparam int STEPS = div_pkg::digit_steps(DVD_W, DIG_W);
    localparam int EXT_W = STEPS * DIG_W;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] trk_q;
    logic [DVS_W-1:0] res_q;
    logic [DVS_W-1:0] dvs_q;
    logic             zero_q;
    logic [DVS_W-1:0] res_nxt;
    logic [DIG_W-1:0] dig_nxt;

    div_digit_step #(.DVS_W(DVS_W), .DIG_W(DIG_W)) u_step (
        .res_i (res_q),
        .dvs_i (dvs_q),
        .bits_i(trk_q[EXT_W-1 -: DIG_W]),
        .res_o (res_nxt),
        .q_o   (dig_nxt)
    );

    // Load operands on an accepted start, otherwise run one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            trk_q  <= '0;
            res_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(STEPS);
            trk_q  <= EXT_W'(dividend);
            res_q  <= '0;
            dvs_q  <= divisor;
            zero_q <= (divisor == '0);
        end else if (busy_q) begin
            if (EXT_W > DIG_W) trk_q <= {trk_q[EXT_W-DIG_W-1:0], dig_nxt};
            else               trk_q <= EXT_W'(dig_nxt);
            res_q  <= res_nxt;
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != CNT_W'(1));
        end
    end

    assign ready     = !busy_q;
    assign quotient  = trk_q[DVD_W-1:0];
    assign remainder = res_q;
    assign div_zero  = zero_q;

    a_r4_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start) |=> !ready);
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0 && cnt_q <= CNT_W'(STEPS)));
    a_r5_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != CNT_W'(1)) |=> $stable(dvs_q));
    a_r2_residue_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !zero_q) |=> (res_q < dvs_q));
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

// File: rtl/div_pipe_core.sv
// Module: div_pipe_core
// Unrolled datapath: a capture stage followed by STEPS register stages, with
// one div_digit_step between each pair. A start is accepted on every cycle.
// A stage loads only when its predecessor holds a valid token, so the last
// stage holds its result until the next one arrives. The zero-divisor flag
// is registered at the last stage only. Synchronous active-low reset.
module div_pipe_core #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 6,
    parameter int DIG_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             ready,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder,
    output logic             div_zero
);
    localparam int STEPS = div_pkg::digit_steps(DVD_W, DIG_W);
    localparam int EXT_W = STEPS * DIG_W;

    logic [STEPS:0]   vld_q;
    logic [EXT_W-1:0] trk_q   [STEPS+1];
    logic [DVS_W-1:0] res_q   [STEPS+1];
    logic [DVS_W-1:0] dvs_q   [STEPS+1];
    logic [DVS_W-1:0] res_nxt [STEPS+1];
    logic [DIG_W-1:0] dig_nxt [STEPS+1];
    logic             zero_q;

    assign res_nxt[0] = '0;
    assign dig_nxt[0] = '0;

    for (genvar s = 1; s <= STEPS; s++) begin : g_step
        div_digit_step #(.DVS_W(DVS_W), .DIG_W(DIG_W)) u_step (
            .res_i (res_q[s-1]),
            .dvs_i (dvs_q[s-1]),
            .bits_i(trk_q[s-1][EXT_W-1 -: DIG_W]),
            .res_o (res_nxt[s]),
            .q_o   (dig_nxt[s])
        );
    end

    // Advance valid tokens and load each stage from its predecessor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            zero_q <= 1'b0;
            for (int s = 0; s <= STEPS; s++) begin
                trk_q[s] <= '0;
                res_q[s] <= '0;
                dvs_q[s] <= '0;
            end
        end else begin
            vld_q <= {vld_q[STEPS-1:0], start};
            if (start) begin
                trk_q[0] <= EXT_W'(dividend);
                res_q[0] <= '0;
                dvs_q[0] <= divisor;
            end
            for (int s = 1; s <= STEPS; s++) begin
                if (vld_q[s-1]) begin
                    if (EXT_W > DIG_W) trk_q[s] <= {trk_q[s-1][EXT_W-DIG_W-1:0], dig_nxt[s]};
                    else               trk_q[s] <= EXT_W'(dig_nxt[s]);
                    res_q[s] <= res_nxt[s];
                    dvs_q[s] <= dvs_q[s-1];
                end
            end
            if (vld_q[STEPS-1]) zero_q <= (dvs_q[STEPS-1] == '0);
        end
    end

    assign ready     = !(|vld_q[STEPS-1:0]);
    assign quotient  = trk_q[STEPS][DVD_W-1:0];
    assign remainder = res_q[STEPS];
    assign div_zero  = zero_q;

    a_r4_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);
    a_r8_hold_without_token: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q[STEPS-1] |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
    a_r7_token_reaches_output: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[STEPS-1] |=> vld_q[STEPS]);
    for (genvar s = 1; s <= STEPS; s++) begin : g_chk
        a_r2_stage_residue_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[s] && dvs_q[s] != '0) |-> (res_q[s] < dvs_q[s]));
    end
endmodule

// File: rtl/restoring_divider.sv
// Module: restoring_divider (top)
// Unsigned divider that retires DIGIT_LOG2 quotient bits per step over
// ceil(DVD_W/DIGIT_LOG2) steps. UNROLL selects the iterative datapath (0) or
// the unrolled one (1). Both present the same handshake at the ports.
module restoring_divider #(
    parameter int DVD_W      = 8,
    parameter int DVS_W      = 6,
    parameter int DIGIT_LOG2 = 1,
    parameter bit UNROLL     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             ready,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder,
    output logic             div_zero
);
    if (UNROLL) begin : g_pipe
        div_pipe_core #(.DVD_W(DVD_W), .DVS_W(DVS_W), .DIG_W(DIGIT_LOG2)) u_core (
            .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
            .dividend(dividend), .divisor(divisor),
            .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
        );
    end else begin : g_iter
        div_iter_core #(.DVD_W(DVD_W), .DVS_W(DVS_W), .DIG_W(DIGIT_LOG2)) u_core (
            .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
            .dividend(dividend), .divisor(divisor),
            .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
        );
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (ready && quotient == '0 && remainder == '0 && !div_zero));
endmodule

// File: tb/restoring_divider_tb.sv
// Bench: six divider configurations share one stimulus stream. There are
// 1-, 2- and 3-bit digits, each in the iterative and the unrolled form.
module restoring_divider_tb;
    localparam int NCFG = 6;
    localparam int AW   = 8;
    localparam int DW   = 6;
    localparam int NVEC = 16;
    // Each vector is {dividend, divisor}; all use a nonzero divisor.
    localparam logic [AW+DW-1:0] VEC [NVEC] = '{
        {8'd200, 6'd7},  {8'd255, 6'd1},  {8'd255, 6'd63}, {8'd0,   6'd5},
        {8'd5,   6'd9},  {8'd62,  6'd63}, {8'd63,  6'd63}, {8'd128, 6'd2},
        {8'd1,   6'd1},  {8'd254, 6'd3},  {8'd100, 6'd10}, {8'd17,  6'd32},
        {8'd127, 6'd16}, {8'd64,  6'd63}, {8'd255, 6'd2},  {8'd129, 6'd43}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW-1:0]   dvd = '0;
    logic [DW-1:0]   dvs = '0;
    logic [NCFG-1:0] rdy;
    logic [NCFG-1:0] dz;
    logic [AW-1:0]   quo [NCFG];
    logic [DW-1:0]   rem [NCFG];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        restoring_divider #(.DVD_W(AW), .DVS_W(DW), .DIGIT_LOG2((g % 3) + 1),
                            .UNROLL(g >= 3)) u_dut (
            .clk(clk), .rst_n(rst_n), .start(start), .ready(rdy[g]),
            .dividend(dvd), .divisor(dvs),
            .quotient(quo[g]), .remainder(rem[g]), .div_zero(dz[g])
        );
    end

    function automatic int steps_of(input int g);
        int k;
        k = (g % 3) + 1;
        return (AW + k - 1) / k;
    endfunction

    task automatic chk(input bit ok, input string req, input int g, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cfg%0d actual %0d expected %0d", req, g, act, exp);
        end
    endtask

    // Check one finished result on every configuration.
    task automatic check_result(input logic [AW-1:0] a, input logic [DW-1:0] d, input int g);
        if (d == '0) begin
            chk(dz[g] == 1'b1, "R6", g, dz[g], 1);
        end else begin
            chk(dz[g] == 1'b0, "R6", g, dz[g], 0);
            if (d > a) begin
                chk(quo[g] == '0, "R3", g, quo[g], 0);
                chk(rem[g] == DW'(a), "R3", g, rem[g], a);
            end
            chk(quo[g] == a / d, "R2", g, quo[g], a / d);
            chk(rem[g] == DW'(a % d), "R2", g, rem[g], a % d);
            chk(rem[g] < d && quo[g] * d + rem[g] == a, "R2", g, rem[g], a % d);
        end
    endtask

    // Issue one division, check ready timing on every edge, then the result.
    task automatic run_div(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        start = 1'b1; dvd = a; dvs = d;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= 9; c++) begin
            if (c > 0) @(negedge clk);
            for (int g = 0; g < NCFG; g++)
                chk(rdy[g] == (c >= steps_of(g)), "R4", g, rdy[g], c >= steps_of(g));
        end
        for (int g = 0; g < NCFG; g++) check_result(a, d, g);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            chk(rdy[g] == 1'b1, "R1", g, rdy[g], 1);
            chk(quo[g] == '0 && rem[g] == '0, "R1", g, quo[g], 0);
            chk(dz[g] == 1'b0, "R1", g, dz[g], 0);
        end
        rst_n = 1'b1;

        // R2/R3/R4: vector table
        for (int i = 0; i < NVEC; i++) run_div(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);

        // R2: random operands
        for (int i = 0; i < 40; i++) begin
            ra = AW'($urandom);
            rd = DW'($urandom);
            if (rd == '0) rd = DW'(1);
            run_div(ra, rd);
        end

        // R6: zero divisor, then a nonzero one clears the flag
        run_div(8'd77, 6'd0);
        run_div(8'd77, 6'd11);

        // R8: results hold while idle
        repeat (5) @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            chk(quo[g] == 8'd7 && rem[g] == 6'd0, "R8", g, quo[g], 7);
            chk(dz[g] == 1'b0, "R8", g, dz[g], 0);
        end

        // R5/R7: second start two cycles into a run
        @(negedge clk);
        start = 1'b1; dvd = 8'd200; dvs = 6'd7;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; dvd = 8'd100; dvs = 6'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            if (g < 3) begin
                chk(quo[g] == 8'd28 && rem[g] == 6'd4, "R5", g, quo[g], 28);
            end else begin
                chk(quo[g] == 8'd33 && rem[g] == 6'd1, "R7", g, quo[g], 33);
            end
        end

        // R7: back-to-back starts on the unrolled form
        @(negedge clk);
        start = 1'b1; dvd = 8'd250; dvs = 6'd9;
        @(negedge clk);
        dvd = 8'd31; dvs = 6'd4;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 9; c++) begin
            if (c > 1) @(negedge clk);
            for (int g = 3; g < NCFG; g++) begin
                chk(rdy[g] == (c >= steps_of(g) + 1), "R7", g, rdy[g], c >= steps_of(g) + 1);
                if (c == steps_of(g))
                    chk(quo[g] == 8'd27 && rem[g] == 6'd7, "R7", g, quo[g], 27);
                if (c == steps_of(g) + 1)
                    chk(quo[g] == 8'd7 && rem[g] == 6'd3, "R7", g, quo[g], 7);
            end
        end
        repeat (4) @(negedge clk);

        // R9: reset in the middle of a division
        start = 1'b1; dvd = 8'd240; dvs = 6'd13;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        for (int g = 0; g < NCFG; g++) chk(rdy[g] == 1'b0, "R9", g, rdy[g], 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < NCFG; g++) begin
            chk(rdy[g] == 1'b1, "R9", g, rdy[g], 1);
            chk(quo[g] == '0 && rem[g] == '0, "R9", g, quo[g], 0);
        end
        run_div(8'd240, 6'd13);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule